// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block is one programmable DMA channel. A CPU loads a 20-bit source pointer, a 20-bit destination pointer and a 16-bit unit counter through an 8-bit register port, picks where requests come from, and then turns the channel on. Every accepted request moves exactly one unit of 8 or 16 bits. The unit is read from the source address and then written to the destination address over a simple memory bus that uses a valid/ready handshake.

After each unit, the pointer that is set to step forward advances by the unit size, and the counter counts down. The counter holds one less than the number of units to move. When the unit taken at a count of zero finishes, the channel either stops (single mode) or restores its pointers and count from copies taken when it was enabled (repeat mode). In both modes it raises a one-cycle completion pulse.

Top module: `dma_chan`

## Requirements
- R1: Register slots (byte address: content): 0..2 source pointer bytes (low first), 3..5 destination pointer bytes, 6..7 counter bytes (low first), 8 control, 9 cause. The top pointer byte stores only address bits 19:16, and its upper nibble always reads as 0. A read returns the slot addressed at the previous clock edge.
- R2: A counter value of N-1 moves N units. The counter decrements after each unit and stays at 0 once the last unit of a single-mode run is done.
- R3: Control bit 0 set selects 8-bit units (bus_byte=1, pointer step 1, only the low byte of memory written). Control bit 0 clear selects 16-bit units (step 2, both bytes written).
- R4: Control bit 4 (source) and bit 5 (destination) select forward stepping when 1 and a fixed address when 0.
- R5: A control write with both bit 4 and bit 5 set leaves both direction bits at their previous values. It still updates the other control bits.
- R6: When cause bits 3:0 hold 4'b0001, writing cause bit 4 as 1 sets the request bit (control bit 2), and ext_req is ignored. With any other cause value, ext_req high for a cycle sets the request bit.
- R7: While the enable bit (control bit 3) is 0, a request is latched in control bit 2 but produces no bus access.
- R8: The request bit clears when the channel accepts its transfer. A control write sets the request bit to the written value, so it can be cleared in the same write that sets enable.
- R9: In single mode (control bit 1 = 0), finishing the unit taken at count zero clears the enable bit and pulses done for exactly one cycle.
- R10: In repeat mode (control bit 1 = 1), finishing the unit taken at count zero reloads the pointers and counter to the values they held when enable was last written from 0 to 1. The channel stays enabled and pulses done.
- R11: bus_valid, bus_addr and bus_write hold steady until bus_ready is seen, so wait states of any length are tolerated.
- R12: Each unit is one read of the source address, followed by one write of the read data to the destination address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register slot address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data of the addressed slot |
| ext_req | input | 1 | Generic external transfer request |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_byte | output | 1 | 1 = 8-bit access, 0 = 16-bit access |
| bus_addr | output | 20 | Bus byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ready on a read |
| bus_ready | input | 1 | Access accepted this cycle |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The bench builds the block with its default parameters: 20-bit addresses, a 16-bit counter, a 16-bit data bus and a 4-bit register address. The top pointer byte's upper nibble and the full 20-bit pointer readback therefore come within reach, and the bench uses them to check the byte-slot layout. The counter is loaded with small values so that the end of the count, the single-mode stop and the repeat-mode reload are all reached in a few dozen units. The bench memory model inserts 0, 1 or 2 wait states per access, which exercises the handshake stall in both the read and the write phase.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // control byte layout, MSB first: bit5 dst_fwd .. bit0 unit8
  typedef struct packed {
    logic dst_fwd;
    logic src_fwd;
    logic enable;
    logic req;
    logic rpt;
    logic unit8;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_UPD
  } eng_state_t;

  localparam logic [3:0] CAUSE_SW = 4'b0001;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              ext_req,
  input  logic              eng_start,
  input  logic              eng_unit_done,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output ctrl_t             ctrl,
  output logic              unit_last
);
  localparam int PTR_BYTES  = (ADDR_W + 7) / 8;
  localparam int CNT_BYTES  = (CNT_W + 7) / 8;
  localparam int PTR_BITS   = PTR_BYTES * 8;
  localparam int CNT_BITS   = CNT_BYTES * 8;
  localparam int DST_BASE   = PTR_BYTES;
  localparam int CNT_BASE   = 2 * PTR_BYTES;
  localparam int CTRL_SLOT  = CNT_BASE + CNT_BYTES;
  localparam int CAUSE_SLOT = CTRL_SLOT + 1;

  logic [ADDR_W-1:0] src_q, dst_q, src_n, dst_n, src_sh, dst_sh;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_sh;
  ctrl_t             ctrl_q, ctrl_n;
  logic [3:0]        cause_q, cause_n;
  logic [PTR_BITS-1:0] src_w, dst_w;
  logic [CNT_BITS-1:0] cnt_w;
  logic [ADDR_W-1:0] step_a;
  logic [7:0]        rd_n;
  logic              set_evt, arm, ctrl_hit;

  assign ctrl_hit = cpu_we && (cpu_addr == REG_AW'(CTRL_SLOT));
  assign set_evt  = (cause_q == CAUSE_SW)
                  ? (cpu_we && cpu_addr == REG_AW'(CAUSE_SLOT) && cpu_wdata[4])
                  : ext_req;
  assign arm      = ctrl_hit && cpu_wdata[3] && !ctrl_q.enable;
  assign step_a   = ctrl_q.unit8 ? ADDR_W'(1) : ADDR_W'(2);

  always_comb begin
    src_w   = PTR_BITS'(src_q);
    dst_w   = PTR_BITS'(dst_q);
    cnt_w   = CNT_BITS'(cnt_q);
    ctrl_n  = ctrl_q;
    cause_n = cause_q;
    if (cpu_we) begin
      for (int b = 0; b < PTR_BYTES; b++) begin
        if (cpu_addr == REG_AW'(b))            src_w[b*8 +: 8] = cpu_wdata;
        if (cpu_addr == REG_AW'(DST_BASE + b)) dst_w[b*8 +: 8] = cpu_wdata;
      end
      for (int b = 0; b < CNT_BYTES; b++) begin
        if (cpu_addr == REG_AW'(CNT_BASE + b)) cnt_w[b*8 +: 8] = cpu_wdata;
      end
      if (cpu_addr == REG_AW'(CAUSE_SLOT)) cause_n = cpu_wdata[3:0];
    end
    if (ctrl_hit) begin
      ctrl_n.unit8  = cpu_wdata[0];
      ctrl_n.rpt    = cpu_wdata[1];
      ctrl_n.req    = cpu_wdata[2];
      ctrl_n.enable = cpu_wdata[3];
      if (!(cpu_wdata[4] && cpu_wdata[5])) begin
        ctrl_n.src_fwd = cpu_wdata[4];
        ctrl_n.dst_fwd = cpu_wdata[5];
      end
    end
    src_n = src_w[ADDR_W-1:0];
    dst_n = dst_w[ADDR_W-1:0];
    cnt_n = cnt_w[CNT_W-1:0];
    if (eng_start) ctrl_n.req = 1'b0;
    if (set_evt)   ctrl_n.req = 1'b1;
    if (eng_unit_done) begin
      if (ctrl_q.src_fwd) src_n = src_q + step_a;
      if (ctrl_q.dst_fwd) dst_n = dst_q + step_a;
      if (cnt_q == '0) begin
        if (ctrl_q.rpt) begin
          src_n = src_sh;
          dst_n = dst_sh;
          cnt_n = cnt_sh;
        end else begin
          ctrl_n.enable = 1'b0;
        end
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_comb begin
    logic [PTR_BITS-1:0] sr, dr;
    logic [CNT_BITS-1:0] cr;
    sr   = PTR_BITS'(src_q);
    dr   = PTR_BITS'(dst_q);
    cr   = CNT_BITS'(cnt_q);
    rd_n = '0;
    for (int b = 0; b < PTR_BYTES; b++) begin
      if (cpu_addr == REG_AW'(b))            rd_n = sr[b*8 +: 8];
      if (cpu_addr == REG_AW'(DST_BASE + b)) rd_n = dr[b*8 +: 8];
    end
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (cpu_addr == REG_AW'(CNT_BASE + b)) rd_n = cr[b*8 +: 8];
    end
    if (cpu_addr == REG_AW'(CTRL_SLOT))  rd_n = {2'b00, ctrl_q};
    if (cpu_addr == REG_AW'(CAUSE_SLOT)) rd_n = {4'b0000, cause_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      src_sh    <= '0;
      dst_sh    <= '0;
      cnt_sh    <= '0;
      ctrl_q    <= '0;
      cause_q   <= '0;
      cpu_rdata <= '0;
    end else begin
      src_q     <= src_n;
      dst_q     <= dst_n;
      cnt_q     <= cnt_n;
      ctrl_q    <= ctrl_n;
      cause_q   <= cause_n;
      cpu_rdata <= rd_n;
      if (arm) begin
        src_sh <= src_q;
        dst_sh <= dst_q;
        cnt_sh <= cnt_q;
      end
    end
  end

  assign src_ptr   = src_q;
  assign dst_ptr   = dst_q;
  assign ctrl      = ctrl_q;
  assign unit_last = (cnt_q == '0);

  // R5: the two forward-step bits are never both set
  p_dir_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.src_fwd && ctrl_q.dst_fwd));

  // R8: an accepted request leaves the request bit clear unless re-raised
  p_req_clear_r8: assert property (@(posedge clk) disable iff (rst)
    eng_start && !set_evt |=> !ctrl_q.req);

  // R9: single-mode end of count drops enable
  p_single_stop_r9: assert property (@(posedge clk) disable iff (rst)
    eng_unit_done && unit_last && !ctrl_q.rpt |=> !ctrl_q.enable);

  // R10: repeat-mode end of count restores the count and stays enabled
  p_repeat_reload_r10: assert property (@(posedge clk) disable iff (rst)
    eng_unit_done && unit_last && ctrl_q.rpt && !cpu_we
    |=> (cnt_q == $past(cnt_sh)) && ctrl_q.enable);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              req,
  input  logic              unit8,
  input  logic [ADDR_W-1:0] src_ptr,
  input  logic [ADDR_W-1:0] dst_ptr,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              start,
  output logic              unit_done,
  output logic              bus_valid,
  output logic              bus_write,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  eng_state_t state;

  assign start     = (state == ST_IDLE) && enable && req;
  assign unit_done = (state == ST_UPD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_byte  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_RD;
          bus_valid <= 1'b1;
          bus_write <= 1'b0;
          bus_byte  <= unit8;
          bus_addr  <= src_ptr;
        end
        ST_RD: if (bus_ready) begin
          state     <= ST_WR;
          bus_write <= 1'b1;
          bus_addr  <= dst_ptr;
          bus_wdata <= bus_byte ? {{(DATA_W-8){1'b0}}, bus_rdata[7:0]} : bus_rdata;
        end
        ST_WR: if (bus_ready) begin
          state     <= ST_UPD;
          bus_valid <= 1'b0;
          bus_write <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: a pending access holds still through wait states
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready
    |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

  // R12: a completed read is followed directly by a write
  p_read_then_write_r12: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready && !bus_write |=> bus_valid && bus_write);

  // R7: an idle, disabled channel stays off the bus
  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && !enable |=> !bus_valid);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              ext_req,
  output logic              bus_valid,
  output logic              bus_write,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              done
);
  logic [ADDR_W-1:0] src_ptr, dst_ptr;
  ctrl_t             ctrl;
  logic              unit_last, eng_start, eng_unit_done;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_req(ext_req),
    .eng_start(eng_start), .eng_unit_done(eng_unit_done),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .ctrl(ctrl), .unit_last(unit_last)
  );

  dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst), .enable(ctrl.enable), .req(ctrl.req),
    .unit8(ctrl.unit8), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .start(eng_start),
    .unit_done(eng_unit_done), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= eng_unit_done && unit_last;
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        ext_req = 1'b0;
  logic        bus_valid, bus_write, bus_byte, done;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;

  logic [7:0] mem [0:255];
  int wait_n = 0, wcnt = 0, acc_cnt = 0, done_cnt = 0;
  int n_chk = 0, n_fail = 0;
  logic [7:0] a0, a1;

  always #4 clk = ~clk;

  dma_chan u_dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_req(ext_req),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .done(done)
  );

  // memory model with programmable wait states
  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_ready) begin
      bus_ready = 1'b0;
      wcnt = 0;
    end else if (bus_valid) begin
      if (wcnt >= wait_n) begin
        bus_ready = 1'b1;
        a0 = bus_addr[7:0];
        a1 = a0 + 8'd1;
        if (bus_write) begin
          mem[a0] = bus_wdata[7:0];
          if (!bus_byte) mem[a1] = bus_wdata[15:8];
        end else begin
          bus_rdata = {mem[a1], mem[a0]};
        end
      end else begin
        wcnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst && bus_valid && bus_ready) acc_cnt++;
    if (!rst && done) done_cnt++;
  end

  function automatic logic [7:0] ini(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic rd_ptr(input logic [3:0] base, output logic [19:0] p);
    logic [7:0] b0, b1, b2;
    rd(base, b0); rd(base + 4'd1, b1); rd(base + 4'd2, b2);
    p = {b2[3:0], b1, b0};
  endtask

  task automatic load(input logic [19:0] s, input logic [19:0] d,
                      input logic [15:0] n1, input logic [7:0] ctl);
    wr(4'd8, 8'h00);
    wr(4'd0, s[7:0]);  wr(4'd1, s[15:8]);  wr(4'd2, {4'h0, s[19:16]});
    wr(4'd3, d[7:0]);  wr(4'd4, d[15:8]);  wr(4'd5, {4'h0, d[19:16]});
    wr(4'd6, n1[7:0]); wr(4'd7, n1[15:8]);
    wr(4'd9, 8'h01);
    wr(4'd8, ctl);
  endtask

  task automatic trig();
    wr(4'd9, 8'h11);
    repeat (25) @(negedge clk);
  endtask

  // {src8, dst8, unit8, sfwd, dfwd, units[3:0], waits[1:0]}
  localparam logic [24:0] VEC [4] = '{
    {8'h10, 8'h80, 1'b1, 1'b1, 1'b0, 4'd4, 2'd0},
    {8'h20, 8'h40, 1'b0, 1'b0, 1'b1, 4'd3, 2'd2},
    {8'h30, 8'h60, 1'b1, 1'b0, 1'b1, 4'd5, 2'd1},
    {8'h08, 8'hC0, 1'b0, 1'b1, 1'b0, 4'd2, 2'd0}
  };

  initial begin
    logic [7:0]  b;
    logic [19:0] p;
    int a0_acc, d0;
    for (int i = 0; i < 256; i++) mem[i] = ini(8'(i));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R9 done low after reset", done, 0);
    chk("R7 no bus access after reset", bus_valid, 0);
    rd(4'd8, b);  chk("R1 control reset value", b, 8'h00);
    rd(4'd6, b);  chk("R2 counter reset value", b, 8'h00);

    // R1: top pointer byte keeps bits 19:16 only
    wr(4'd2, 8'hFA);
    rd(4'd2, b);  chk("R1 top byte upper nibble reads 0", b, 8'h0A);

    // table-driven transfers
    for (int i = 0; i < 4; i++) begin
      logic [24:0] v;
      logic [19:0] s, d, ls, ld, fs, fd;
      logic [7:0]  ctl;
      int n, st;
      v  = VEC[i];
      wait_n = int'(v[1:0]);
      n  = int'(v[5:2]);
      st = v[8] ? 1 : 2;
      s  = 20'hA0000 | {12'h0, v[24:17]};
      d  = 20'h50000 | {12'h0, v[16:9]};
      ls = s + (v[7] ? 20'((n - 1) * st) : 20'h0);
      ld = d + (v[6] ? 20'((n - 1) * st) : 20'h0);
      fs = s + (v[7] ? 20'(n * st) : 20'h0);
      fd = d + (v[6] ? 20'(n * st) : 20'h0);
      ctl = {2'b00, v[6], v[7], 3'b000, v[8]};
      load(s, d, 16'(n - 1), ctl);
      wr(4'd8, ctl | 8'h08);
      a0_acc = acc_cnt; d0 = done_cnt;
      for (int k = 0; k < n; k++) trig();
      chk($sformatf("R12 vec%0d read+write per unit", i), acc_cnt - a0_acc, 2 * n);
      chk($sformatf("R11 vec%0d low byte moved under waits", i), mem[ld[7:0]], ini(ls[7:0]));
      if (v[8])
        chk($sformatf("R3 vec%0d byte unit leaves upper lane", i),
            mem[ld[7:0] + 8'd1], ini(ld[7:0] + 8'd1));
      else
        chk($sformatf("R3 vec%0d high byte moved", i), mem[ld[7:0] + 8'd1], ini(ls[7:0] + 8'd1));
      rd_ptr(4'd0, p); chk($sformatf("R4 vec%0d source pointer", i), p, fs);
      rd_ptr(4'd3, p); chk($sformatf("R4 vec%0d destination pointer", i), p, fd);
      rd(4'd6, b);     chk($sformatf("R2 vec%0d counter at zero", i), b, 8'h00);
      rd(4'd8, b);     chk($sformatf("R9 vec%0d enable cleared", i), b[3], 1'b0);
      chk($sformatf("R9 vec%0d one done pulse", i), done_cnt - d0, 1);
    end
    wait_n = 0;

    // R5: both directions forward is refused
    wr(4'd8, 8'h10);
    wr(4'd8, 8'h31);
    rd(4'd8, b);  chk("R5 directions kept, other bits written", b, 8'h11);

    // R7/R8: request while disabled, then enable keeping the request
    load(20'h00070, 20'h000D0, 16'd0, 8'h11);
    a0_acc = acc_cnt;
    wr(4'd9, 8'h11);
    repeat (15) @(negedge clk);
    rd(4'd8, b);  chk("R7 request latched while disabled", b[2], 1'b1);
    chk("R7 no access while disabled", acc_cnt - a0_acc, 0);
    wr(4'd8, 8'h1D);
    repeat (15) @(negedge clk);
    chk("R8 held request served after enable", acc_cnt - a0_acc, 2);
    rd(4'd8, b);  chk("R8 request bit self-cleared", b[2], 1'b0);
    chk("R8 data moved", mem[8'hD0], ini(8'h70));

    // R6: ext_req ignored under software cause, honoured otherwise
    load(20'h00071, 20'h000D8, 16'd0, 8'h11);
    @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    rd(4'd8, b);  chk("R6 ext_req ignored with software cause", b[2], 1'b0);
    wr(4'd9, 8'h00);
    wr(4'd8, 8'h19);
    a0_acc = acc_cnt;
    @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    repeat (15) @(negedge clk);
    chk("R6 ext_req triggers a unit", acc_cnt - a0_acc, 2);
    chk("R6 ext data moved", mem[8'hD8], ini(8'h71));

    // R10: repeat mode reload
    load(20'h00050, 20'h000E0, 16'd1, 8'h13);
    wr(4'd8, 8'h1B);
    d0 = done_cnt;
    trig(); trig();
    rd_ptr(4'd0, p); chk("R10 source reloaded", p, 20'h00050);
    rd(4'd6, b);     chk("R10 counter reloaded", b, 8'h01);
    rd(4'd8, b);     chk("R10 stays enabled", b[3], 1'b1);
    chk("R10 done pulse on reload", done_cnt - d0, 1);
    trig();
    rd_ptr(4'd0, p); chk("R10 next run continues", p, 20'h00051);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule